// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock core. It holds a 32-bit count of seconds, which advances by one on each cycle where the one-second tick input is high. It also holds a 32-bit alarm compare value, a watchdog reload value, and a small set of configuration words. When the count steps onto the alarm value, a sticky alarm flag is set. That flag drives the interrupt line only when software has enabled it in two places: the alarm enable in the persistent configuration word and the alarm interrupt enable in the control word. A separate millisecond tick path can raise a pending flag of its own, which is also merged into the interrupt.

Software reaches the block through a plain 32-bit register port. Each register occupies a 16-byte slot. The control-type registers (control, persistent0 and persistent1) each have three write views: a whole-word write, a bit-set view that ORs in a mask, and a bit-clear view that removes a mask. With these views one bit can be changed without a read-modify-write. Sticky flags are acknowledged through the bit-clear view. Oscillator and clock-source bits are only stored. Two strap inputs report which crystal is fitted.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the control, persistent0, persistent1, seconds, alarm and watchdog registers all read 0 and `irq` is low.
- R2: For a write or read, the register slot is `addr[6:4]` and the write view is `addr[3:2]`: 0 replaces the word, 1 ORs `wdata` in, 2 clears the bits set in `wdata`, and 3 ignores the write. Reads return the slot's register whatever the view bits are. An access with `addr[1:0]` nonzero or with any address bit above bit 6 set matches nothing: it reads 0 and writes nothing. The slots are: control 0x00, status 0x10, seconds 0x30, alarm 0x40, watchdog 0x50, persistent0 0x60, persistent1 0x70. Any other slot reads 0.
- R3: The control register bits are: alarm interrupt enable at bit 0, millisecond interrupt enable at bit 1, alarm flag at bit 2, millisecond pending at bit 3, and watchdog enable at bit 4. Bits 31:5 always read 0.
- R4: Persistent0 stores bit 0 (clock select), bit 1 (alarm wake enable), bit 2 (alarm enable), bit 4 (keep 24 MHz oscillator), bit 5 (keep 32 kHz oscillator), bit 6 (32000 Hz crystal select) and bit 7 (alarm wake flag). Its bit 3 and bits 31:8 read 0. Persistent1 stores all 32 bits.
- R5: The seconds, alarm and watchdog registers take only whole-word writes (view 0). A write to their set or clear view leaves them unchanged.
- R6: The seconds count rises by exactly one at each clock edge where `tick_1s` is high, and it wraps from 0xFFFFFFFF to 0. A whole-word write to seconds in the same cycle takes precedence over the tick.
- R7: The status register reads 1 at bit 31, `strap_xtal_32000` at bit 28, `strap_xtal_32768` at bit 27, and 0 elsewhere. Writes to it have no effect.
- R8: The alarm flag (control bit 2) is set at the clock edge where a tick moves the count onto the alarm value, but only if persistent0 bit 2 is set. At that same edge persistent0 bit 7 is also set if persistent0 bit 1 is set. A direct write of the alarm value into the seconds register does not set the flag.
- R9: The alarm flag and the millisecond pending flag stay set until software clears them. If a hardware set and a software clear of a flag fall in the same cycle, the flag ends up set.
- R10: `irq` equals (alarm flag AND control bit 0 AND persistent0 bit 2) OR millisecond pending. It is decoded from registers, so it changes in the same cycle as the flags it depends on.
- R11: A cycle with `tick_1ms` high sets control bit 3 if control bit 1 was already set. If bit 1 is clear, the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (8) | Byte address: slot, write view, alignment bits |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_1s | input | 1 | One-cycle pulse per second |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| strap_xtal_32000 | input | 1 | Board reports a 32000 Hz crystal |
| strap_xtal_32768 | input | 1 | Board reports a 32768 Hz crystal |
| irq | output | 1 | Interrupt request, level |

## Verification
Every register, flag and counter update lands at the rising edge that samples the write or tick. Because `rdata` and `irq` are decoded directly from registers, both show the new value in the same cycle, with no extra pipeline stage. The bench drives a stimulus on a falling edge and updates its behavioural model at the next rising edge. It then compares `irq` and the `rdata` of the addressed register at the following falling edge. It also checks fixed constants, so an expected value is never read early or late. Bench-side reads of other registers change only `addr`, let a short settle delay pass, and compare within the same low phase.

// File: rtl/rtc_sec_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_sec_alarm_pkg;

   localparam int REG_W     = 32;
   localparam int NUM_SLOTS = 8;
   localparam int SLOT_LSB  = 4;
   localparam int VIEW_LSB  = 2;

   typedef enum logic [1:0] {
      VIEW_WORD = 2'd0,
      VIEW_SET  = 2'd1,
      VIEW_CLR  = 2'd2,
      VIEW_NONE = 2'd3
   } wr_view_e;

   localparam logic [2:0] SLOT_CTRL = 3'd0;
   localparam logic [2:0] SLOT_STAT = 3'd1;
   localparam logic [2:0] SLOT_SECS = 3'd3;
   localparam logic [2:0] SLOT_ALRM = 3'd4;
   localparam logic [2:0] SLOT_WDOG = 3'd5;
   localparam logic [2:0] SLOT_PER0 = 3'd6;
   localparam logic [2:0] SLOT_PER1 = 3'd7;

   // control word fields
   localparam int CB_ALM_IE  = 0;
   localparam int CB_MS_IE   = 1;
   localparam int CB_ALM_FLG = 2;
   localparam int CB_MS_PND  = 3;
   localparam int CB_WD_EN   = 4;

   // persistent0 fields
   localparam int PB_CLKSEL   = 0;
   localparam int PB_WAKE_EN  = 1;
   localparam int PB_ALM_EN   = 2;
   localparam int PB_OSC24    = 4;
   localparam int PB_OSC32    = 5;
   localparam int PB_XSEL     = 6;
   localparam int PB_WAKE_FLG = 7;

   // status fields
   localparam int SB_PRESENT = 31;
   localparam int SB_X32000  = 28;
   localparam int SB_X32768  = 27;

   localparam logic [REG_W-1:0] CTRL_KEEP = 32'h0000_001F;
   localparam logic [REG_W-1:0] PER0_KEEP = 32'h0000_00F7;
   localparam logic [REG_W-1:0] PER1_KEEP = 32'hFFFF_FFFF;

endpackage

// File: rtl/rtc_bus_decode.sv
`timescale 1ns/1ps
module rtc_bus_decode
   import rtc_sec_alarm_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [2:0]        slot_o,
   output wr_view_e          view_o,
   output logic              in_map_o,
   output logic [NUM_SLOTS-1:0] wr_sel_o
);

   localparam int SLOT_MSB = SLOT_LSB + 2;

   if (ADDR_W < SLOT_MSB + 1) begin : g_bad_addr
      $error("rtc_bus_decode: ADDR_W must cover the slot field");
   end

   logic upper_zero;

   if (ADDR_W > SLOT_MSB + 1) begin : g_upper
      assign upper_zero = (addr_i[ADDR_W-1:SLOT_MSB+1] == '0);
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   assign in_map_o = upper_zero && (addr_i[1:0] == 2'b00);
   assign slot_o   = addr_i[SLOT_MSB:SLOT_LSB];
   assign view_o   = wr_view_e'(addr_i[VIEW_LSB+1:VIEW_LSB]);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
      assign wr_sel_o[i] = wr_en_i && in_map_o && (slot_o == 3'(i));
   end

endmodule

// File: rtl/rtc_alias_reg.sv
`timescale 1ns/1ps
module rtc_alias_reg
   import rtc_sec_alarm_pkg::*;
#(
   parameter int           W         = 32,
   parameter logic [W-1:0] KEEP_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  wr_view_e     view_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] hw_set_i,
   output logic [W-1:0] q_o
);

   if (KEEP_MASK == '0) begin : g_bad_mask
      $error("rtc_alias_reg: KEEP_MASK stores no bit");
   end

   logic [W-1:0] sw_val;

   always_comb begin
      sw_val = q_o;
      if (wr_i) begin
         unique case (view_i)
            VIEW_WORD: sw_val = wdata_i;
            VIEW_SET:  sw_val = q_o | wdata_i;
            VIEW_CLR:  sw_val = q_o & ~wdata_i;
            default:   sw_val = q_o;
         endcase
      end
   end

   // hardware events win over a simultaneous software clear
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (sw_val | hw_set_i) & KEEP_MASK;
   end

endmodule

// File: rtl/rtc_sec_counter.sv
`timescale 1ns/1ps
module rtc_sec_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         tick_i,
   input  logic [W-1:0] cmp_val_i,
   output logic [W-1:0] count_o,
   output logic         hit_o
);

   if (W < 2) begin : g_bad_w
      $error("rtc_sec_counter: W too small");
   end

   logic         adv;
   logic [W-1:0] nxt;

   assign adv   = tick_i && !load_i;
   assign nxt   = count_o + W'(1);
   assign hit_o = adv && (nxt == cmp_val_i);

   always_ff @(posedge clk) begin
      if (!rst_n)      count_o <= '0;
      else if (load_i) count_o <= load_val_i;
      else if (adv)    count_o <= nxt;
   end

endmodule

// File: rtl/rtc_sec_alarm.sv
`timescale 1ns/1ps
module rtc_sec_alarm
   import rtc_sec_alarm_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int SEC_W         = 32,
   parameter int WD_W          = 32,
   parameter bit MS_IRQ_GATED  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              tick_1s,
   input  logic              tick_1ms,
   input  logic              strap_xtal_32000,
   input  logic              strap_xtal_32768,
   output logic              irq
);

   if (SEC_W < 8 || SEC_W > REG_W) begin : g_bad_sec
      $error("rtc_sec_alarm: SEC_W out of range");
   end
   if (WD_W < 1 || WD_W > REG_W) begin : g_bad_wd
      $error("rtc_sec_alarm: WD_W out of range");
   end

   logic [2:0]           slot;
   wr_view_e             view;
   logic                 in_map;
   logic [NUM_SLOTS-1:0] wr_sel;

   rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en_i  (wr_en),
      .addr_i   (addr),
      .slot_o   (slot),
      .view_o   (view),
      .in_map_o (in_map),
      .wr_sel_o (wr_sel)
   );

   logic [REG_W-1:0] ctrl_q, per0_q, per1_q;
   logic [REG_W-1:0] ctrl_hw, per0_hw;
   logic [SEC_W-1:0] secs_q, alarm_q;
   logic [WD_W-1:0]  wdog_q;
   logic             sec_hit, alarm_set;
   logic             word_wr;

   assign word_wr = (view == VIEW_WORD);

   // hardware set sources
   assign alarm_set = sec_hit && per0_q[PB_ALM_EN];

   always_comb begin
      ctrl_hw             = '0;
      ctrl_hw[CB_ALM_FLG] = alarm_set;
      ctrl_hw[CB_MS_PND]  = tick_1ms && ctrl_q[CB_MS_IE];
      per0_hw              = '0;
      per0_hw[PB_WAKE_FLG] = alarm_set && per0_q[PB_WAKE_EN];
   end

   rtc_alias_reg #(.W(REG_W), .KEEP_MASK(CTRL_KEEP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_sel[SLOT_CTRL]), .view_i(view),
      .wdata_i(wdata), .hw_set_i(ctrl_hw), .q_o(ctrl_q)
   );

   rtc_alias_reg #(.W(REG_W), .KEEP_MASK(PER0_KEEP)) u_per0 (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_sel[SLOT_PER0]), .view_i(view),
      .wdata_i(wdata), .hw_set_i(per0_hw), .q_o(per0_q)
   );

   rtc_alias_reg #(.W(REG_W), .KEEP_MASK(PER1_KEEP)) u_per1 (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_sel[SLOT_PER1]), .view_i(view),
      .wdata_i(wdata), .hw_set_i('0), .q_o(per1_q)
   );

   rtc_sec_counter #(.W(SEC_W)) u_secs (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_sel[SLOT_SECS] && word_wr),
      .load_val_i (wdata[SEC_W-1:0]),
      .tick_i     (tick_1s),
      .cmp_val_i  (alarm_q),
      .count_o    (secs_q),
      .hit_o      (sec_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '0;
         wdog_q  <= '0;
      end else begin
         if (wr_sel[SLOT_ALRM] && word_wr) alarm_q <= wdata[SEC_W-1:0];
         if (wr_sel[SLOT_WDOG] && word_wr) wdog_q  <= wdata[WD_W-1:0];
      end
   end

   // interrupt merge: the variant picks whether ms pending is masked
   logic alarm_irq, ms_irq;
   assign alarm_irq = ctrl_q[CB_ALM_FLG] && ctrl_q[CB_ALM_IE] && per0_q[PB_ALM_EN];

   if (MS_IRQ_GATED) begin : g_ms_gated
      assign ms_irq = ctrl_q[CB_MS_PND] && ctrl_q[CB_MS_IE];
   end else begin : g_ms_plain
      assign ms_irq = ctrl_q[CB_MS_PND];
   end

   assign irq = alarm_irq || ms_irq;

   // read mux
   always_comb begin
      rdata = '0;
      if (in_map) begin
         unique case (slot)
            SLOT_CTRL: rdata = ctrl_q;
            SLOT_STAT: begin
               rdata[SB_PRESENT] = 1'b1;
               rdata[SB_X32000]  = strap_xtal_32000;
               rdata[SB_X32768]  = strap_xtal_32768;
            end
            SLOT_SECS: rdata = REG_W'(secs_q);
            SLOT_ALRM: rdata = REG_W'(alarm_q);
            SLOT_WDOG: rdata = REG_W'(wdog_q);
            SLOT_PER0: rdata = per0_q;
            SLOT_PER1: rdata = per1_q;
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/rtc_sec_alarm_chk.sv
`timescale 1ns/1ps
module rtc_sec_alarm_chk
   import rtc_sec_alarm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SEC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              tick_1s,
   input logic              tick_1ms,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rdata,
   input logic              irq,
   input logic [REG_W-1:0]  ctrl_q,
   input logic [SEC_W-1:0]  secs_q
);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6
   secs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(wr_en)) |-> (secs_q == $past(secs_q) + SEC_W'($past(tick_1s))));

   // R9
   alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(ctrl_q[CB_ALM_FLG]) && !$past(wr_en)) |-> ctrl_q[CB_ALM_FLG]);

   // R8
   alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(ctrl_q[CB_ALM_FLG])) |-> ($past(tick_1s) || $past(wr_en)));

   // R11
   ms_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(ctrl_q[CB_MS_PND])) |->
         (($past(tick_1ms) && $past(ctrl_q[CB_MS_IE])) || $past(wr_en)));

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CB_ALM_FLG] && !ctrl_q[CB_MS_PND]) |-> !irq);

   // R7
   present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(8'h10)) |-> rdata[SB_PRESENT]);

endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .tick_1s  (tick_1s),
   .tick_1ms (tick_1ms),
   .addr     (addr),
   .rdata    (rdata),
   .irq      (irq),
   .ctrl_q   (ctrl_q),
   .secs_q   (secs_q)
);

// File: tb/rtc_sec_alarm_tb_top.sv
`timescale 1ns/1ps
module rtc_sec_alarm_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick_1s = 1'b0;
   logic        tick_1ms = 1'b0;
   logic        strap_xtal_32000 = 1'b1;
   logic        strap_xtal_32768 = 1'b0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   rtc_sec_alarm dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick_1s(tick_1s), .tick_1ms(tick_1ms),
      .strap_xtal_32000(strap_xtal_32000), .strap_xtal_32768(strap_xtal_32768),
      .irq(irq)
   );

   // behavioural reference state
   logic [31:0] m_ctrl, m_p0, m_p1, m_secs, m_alarm, m_wd;

   function automatic logic [31:0] view_op(input logic [31:0] cur, input logic [31:0] d,
                                            input logic [1:0] v);
      case (v)
         2'd0:    return d;
         2'd1:    return cur | d;
         2'd2:    return cur & ~d;
         default: return cur;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a[7] || a[1:0] != 2'b00) return 32'h0;
      case (a[6:4])
         3'd0: return m_ctrl;
         3'd1: return 32'h8000_0000 | (32'(strap_xtal_32000) << 28) | (32'(strap_xtal_32768) << 27);
         3'd3: return m_secs;
         3'd4: return m_alarm;
         3'd5: return m_wd;
         3'd6: return m_p0;
         3'd7: return m_p1;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic m_irq();
      return (m_ctrl[2] && m_ctrl[0] && m_p0[2]) || m_ctrl[3];
   endfunction

   task automatic model_reset();
      m_ctrl = '0; m_p0 = '0; m_p1 = '0; m_secs = '0; m_alarm = '0; m_wd = '0;
   endtask

   task automatic model_edge();
      logic [31:0] oc  = m_ctrl;
      logic [31:0] op0 = m_p0;
      logic [31:0] oal = m_alarm;
      logic [31:0] nx;
      logic [1:0]  v   = addr[3:2];
      bit secw  = 0;
      bit match = 0;
      if (wr_en && !addr[7] && addr[1:0] == 2'b00) begin
         case (addr[6:4])
            3'd0: m_ctrl = view_op(m_ctrl, wdata, v) & 32'h1F;
            3'd3: if (v == 2'd0) begin m_secs = wdata; secw = 1; end
            3'd4: if (v == 2'd0) m_alarm = wdata;
            3'd5: if (v == 2'd0) m_wd = wdata;
            3'd6: m_p0 = view_op(m_p0, wdata, v) & 32'hF7;
            3'd7: m_p1 = view_op(m_p1, wdata, v);
            default: ;
         endcase
      end
      if (tick_1s && !secw) begin
         nx     = m_secs + 32'd1;
         match  = (nx == oal) && op0[2];
         m_secs = nx;
      end
      if (match) m_ctrl[2] = 1'b1;
      if (tick_1ms && oc[1]) m_ctrl[3] = 1'b1;
      if (match && op0[1]) m_p0[7] = 1'b1;
   endtask

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at falling edge
   task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic ts, input logic tm);
      wr_en = w; addr = a; wdata = d; tick_1s = ts; tick_1ms = tm;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(32'(irq), 32'(m_irq()), "R10 irq vs model");
      check(rdata, m_read(addr), "R2 readback vs model");
      wr_en = 1'b0; tick_1s = 1'b0; tick_1ms = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, 1'b0);
   endtask

   task automatic sec_tick();
      step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      wr_en = 1'b0; addr = a;
      #0.5;
      check(rdata, exp, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, 32'h0, "R1 ctrl after reset");
      rd(8'h30, 32'h0, "R1 seconds after reset");
      rd(8'h60, 32'h0, "R1 persist0 after reset");
      rd(8'h70, 32'h0, "R1 persist1 after reset");
      check(32'(irq), 32'h0, "R1 irq after reset");

      // R7 status and straps
      rd(8'h10, 32'h9000_0000, "R7 status straps 1/0");
      strap_xtal_32000 = 1'b0; strap_xtal_32768 = 1'b1;
      rd(8'h10, 32'h8800_0000, "R7 status straps 0/1");
      wr(8'h10, 32'h0);
      rd(8'h10, 32'h8800_0000, "R7 status write ignored");

      // R3 control field width, R2 views
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'h0000_001F, "R3 ctrl writable bits");
      check(32'(irq), 32'h1, "R10 ms pending raises irq");
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h00, 32'h0, "R2 clear view");
      wr(8'h04, 32'h1);
      wr(8'h04, 32'h10);
      rd(8'h00, 32'h11, "R2 set view ORs");
      wr(8'h08, 32'h1);
      rd(8'h04, 32'h10, "R2 clear view, read at alias");
      wr(8'h0C, 32'h2);
      rd(8'h00, 32'h10, "R2 view 3 ignored");
      wr(8'h80, 32'hFF);
      rd(8'h00, 32'h10, "R2 high address bit misses");
      wr(8'h02, 32'hFF);
      rd(8'h00, 32'h10, "R2 misaligned write misses");
      wr(8'h20, 32'h5);
      rd(8'h20, 32'h0, "R2 unmapped slot reads 0");
      wr(8'h08, 32'h10);

      // R4 persistent registers
      wr(8'h60, 32'hFFFF_FFFF);
      rd(8'h60, 32'h0000_00F7, "R4 persist0 stored bits");
      wr(8'h68, 32'hFFFF_FFFF);
      wr(8'h74, 32'hA5A5_0000);
      wr(8'h74, 32'h0000_005A);
      rd(8'h70, 32'hA5A5_005A, "R4 persist1 set view");
      wr(8'h78, 32'hA500_0000);
      rd(8'h70, 32'h00A5_005A, "R4 persist1 clear view");

      // R5 word-only registers
      wr(8'h34, 32'hFF);
      rd(8'h30, 32'h0, "R5 seconds set view ignored");
      wr(8'h30, 32'd100);
      wr(8'h44, 32'h5);
      rd(8'h40, 32'h0, "R5 alarm set view ignored");
      wr(8'h50, 32'h1234);
      wr(8'h58, 32'h1234);
      rd(8'h50, 32'h1234, "R5 watchdog clear view ignored");

      // R6 counting, precedence, wrap
      sec_tick(); sec_tick(); sec_tick();
      rd(8'h30, 32'd103, "R6 three ticks");
      step(1'b1, 8'h30, 32'd500, 1'b1, 1'b0);
      rd(8'h30, 32'd500, "R6 write beats tick");
      wr(8'h30, 32'hFFFF_FFFF);
      sec_tick();
      rd(8'h30, 32'h0, "R6 wrap to zero");

      // R8 alarm match with both enables
      wr(8'h40, 32'd105);
      wr(8'h30, 32'd103);
      wr(8'h64, 32'h6);
      wr(8'h04, 32'h1);
      sec_tick();
      rd(8'h00, 32'h1, "R8 no flag before match");
      sec_tick();
      rd(8'h00, 32'h5, "R8 flag on match tick");
      check(32'(irq), 32'h1, "R10 alarm irq same cycle");
      rd(8'h60, 32'h86, "R8 wake flag set");
      sec_tick(); sec_tick();
      rd(8'h00, 32'h5, "R9 flag sticky");
      wr(8'h08, 32'h4);
      check(32'(irq), 32'h0, "R9 clear drops irq");
      wr(8'h68, 32'h80);
      rd(8'h60, 32'h6, "R4 wake flag cleared");

      // R8 direct write does not match
      wr(8'h30, 32'd105);
      rd(8'h00, 32'h1, "R8 direct write no flag");

      // R8 persistent alarm enable off
      wr(8'h68, 32'h4);
      wr(8'h30, 32'd104);
      sec_tick();
      rd(8'h00, 32'h1, "R8 alarm enable off, no flag");
      rd(8'h60, 32'h2, "R8 no wake flag when disabled");

      // R10 interrupt enable off then on
      wr(8'h64, 32'h4);
      wr(8'h08, 32'h1);
      wr(8'h30, 32'd104);
      sec_tick();
      rd(8'h00, 32'h4, "R10 flag without enable");
      check(32'(irq), 32'h0, "R10 irq masked");
      wr(8'h04, 32'h1);
      check(32'(irq), 32'h1, "R10 irq after enable");

      // R9 hardware set beats software clear
      wr(8'h08, 32'h4);
      wr(8'h30, 32'd104);
      step(1'b1, 8'h08, 32'h4, 1'b1, 1'b0);
      rd(8'h00, 32'h5, "R9 set wins over clear");
      wr(8'h08, 32'h5);
      wr(8'h68, 32'h80);

      // R11 millisecond path
      step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
      rd(8'h00, 32'h0, "R11 ms tick ignored when disabled");
      check(32'(irq), 32'h0, "R11 no irq when disabled");
      wr(8'h04, 32'h2);
      step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
      rd(8'h00, 32'hA, "R11 ms pending set");
      check(32'(irq), 32'h1, "R11 ms irq");
      wr(8'h08, 32'h8);
      rd(8'h00, 32'h2, "R9 ms pending cleared");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule